// File: doc/BRIEF.md
# Video PHY Power Mode Sequencer

This block brings a combined video PHY (serial camera/display lanes, LVDS or parallel TTL output) up and down without software stepping through it. A single power-on or power-off request starts a fixed program of register updates. Each update is a masked read-modify-write sent over a small internal register bus. The program also inserts timed reset pulses and, in LVDS mode, polls a PLL lock input. The PHY's analog macro and its PLL sit outside the block.

Each register address packs a 3-bit part index above a 5-bit register index. The parts are 0 analog, 1 digital, 2 clock lane, 3 to 6 data lanes, and 7 LVDS. The bus target changes only the bits set in the mask. The outgoing bus is a valid/ready stream that carries one transaction at a time. While `bus_valid` is high and `bus_ready` is low, the block holds address, mask and data steady, and the sequence waits. A transfer happens on any rising edge where both are high. The target may hold `bus_ready` low for as long as it needs, and no data is lost. Request, mode, divider, lock and status pins are plain levels.

A timebase of `CYCLES_PER_US` clock cycles per microsecond sets the reset pulse width and the lock polling grid. The mode and divider inputs are captured when a power-on request is accepted.

Top module: `vphy_pwr_seq`

## Requirements
- R1: Address bits 7:5 carry the part and bits 4:0 the register. While `bus_valid` is high and `bus_ready` low, `bus_valid`, `bus_addr`, `bus_mask` and `bus_data` hold. Only one transaction is presented at a time, and every transaction is sent while `busy` is high.
- R2: Every power-on starts with two writes to analog register 0. The first uses mask 0x80 with data 0x00 to power the bandgap. The second uses mask 0x03 with data 0x01 to enable the work field.
- R3: With mode 2'b00, the prefix is followed in order by these writes:
  - 0xE3 mask 0x07 data 0x01
  - 0x03 mask 0x1F data prediv
  - 0x03 mask 0x20 data fbdiv[8] placed at bit 5
  - 0x04 mask 0xFF data fbdiv[7:0]
  - 0x01 mask 0x03 data 0x00
  - 0x01 mask 0x04 with data 0x04 then 0x00
  - 0x20 mask 0x01 with data 0x00 then 0x01
  - 0x00 mask 0x7C data 0x7C
- R4: In each reset pulse, the release write is accepted no earlier than `CYCLES_PER_US` cycles after the assert write. This applies to the analog sync reset 0x01/0x04, the digital reset 0x20/0x01 and the LVDS digital reset 0xE0/0x04.
- R5: With mode 2'b01, the prefix is followed in order by these writes:
  - 0x08 mask 0x30 data 0x10
  - 0xE3 mask 0x07 data 0x02
  - 0x03 mask 0x1F data 0x02
  - 0x03 mask 0x20 data 0x00
  - 0x04 mask 0xFF data 0x1C
  - 0xE8 mask 0xFF data 0xFC
  - 0xEB mask 0x05 data 0x00
  - a lock poll
  - 0x1E mask 0x60 data 0x00
  - the shared tail: 0xE0 mask 0x04 with data 0x00 then 0x04, 0xE1 mask 0x80 data 0x80, 0xEB mask 0xF8 data 0xF8
- R6: The lock poll samples `pll_lock` on entry and then every `POLL_US` microseconds. The sequence continues at the first sample that sees lock. If no sample sees lock by `LOCK_TIMEOUT_US`, the block sets `lock_timeout` and still finishes the sequence. The flag clears when the next request is accepted.
- R7: Modes 2'b10 and 2'b11 run the prefix, then 0xE3 mask 0x07 data 0x04, then the shared tail. After the last tail write, the block sets `host_clk_en`, and it stays set until reset.
- R8: Power-off sends these writes in order:
  - 0x00 mask 0x7C data 0x00
  - 0x01 mask 0x03 data 0x03
  - 0x00 mask 0x03 data 0x02
  - 0x00 mask 0x80 data 0x80
  - 0xEB mask 0xF8 data 0x00
  - 0xE1 mask 0x80 data 0x00
  - 0xEB mask 0x05 data 0x05
- R9: An accepted request raises `busy` on the next cycle. `done` is a one-cycle pulse in the first cycle that `busy` is low again. Requests that arrive while busy are ignored. If both requests arrive together, power-off wins.
- R10: After reset, `bus_valid`, `busy`, `done`, `host_clk_en` and `lock_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Start the power-on program for `mode` |
| pwr_off_req | input | 1 | Start the power-off program |
| mode | input | 2 | 00 serial lanes, 01 LVDS, 10/11 TTL |
| prediv | input | 5 | PLL pre-divider for mode 00 |
| fbdiv | input | 9 | PLL feedback divider for mode 00 |
| pll_lock | input | 1 | PLL lock status |
| bus_valid | output | 1 | Register transaction presented |
| bus_ready | input | 1 | Target accepts the transaction |
| bus_addr | output | 8 | Part (7:5) and register (4:0) |
| bus_mask | output | 8 | Bits to change |
| bus_data | output | 8 | New values for the masked bits |
| host_clk_en | output | 1 | Host clock-lane enable set by TTL power-on |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| lock_timeout | output | 1 | No PLL lock seen within the limit |

## Verification
`busy` is due one edge after a request is sampled. The bench checks it at the next falling edge and looks for `done` at the first falling edge where it is high. Each transaction is logged on the rising edge where valid and ready are both high, so a stall pattern on `bus_ready` moves when transactions happen but never changes their order. Reset pulse widths are taken from the logged acceptance cycles, which must be at least one microsecond of cycles apart. Lock handling is placed on the polling grid. A late lock must produce the 0x1E write within one poll interval of the lock, and a missing lock must hold that write back by the full timeout.

// File: rtl/vphy_seq_pkg.sv
package vphy_seq_pkg;

  localparam int PC_W = 6;

  typedef enum logic [2:0] {K_WR, K_WAIT, K_POLL, K_HOST, K_END} kind_t;

  typedef struct packed {
    kind_t      kind;
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] data;
  } step_t;

  // part indices, decoded by the PHY from address bits 7:5
  localparam logic [2:0] PART_ANA  = 3'd0;
  localparam logic [2:0] PART_DIG  = 3'd1;
  localparam logic [2:0] PART_LVDS = 3'd7;

  // program entry points
  localparam logic [PC_W-1:0] PC_SER  = 6'd0;
  localparam logic [PC_W-1:0] PC_LVDS = 6'd16;
  localparam logic [PC_W-1:0] PC_TTL  = 6'd33;
  localparam logic [PC_W-1:0] PC_OFF  = 6'd48;

  function automatic step_t wr(logic [2:0] part, logic [4:0] idx,
                               logic [7:0] mask, logic [7:0] data);
    step_t s;
    s.kind = K_WR;
    s.addr = {part, idx};
    s.mask = mask;
    s.data = data;
    return s;
  endfunction

  function automatic step_t ctl(kind_t k);
    step_t s;
    s.kind = k;
    s.addr = '0;
    s.mask = '0;
    s.data = '0;
    return s;
  endfunction

endpackage

// File: rtl/vphy_us_timer.sv
module vphy_us_timer #(
  parameter int CYCLES_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int CW = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/vphy_step_rom.sv
module vphy_step_rom
  import vphy_seq_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  input  logic [4:0]      prediv,
  input  logic [8:0]      fbdiv,
  output step_t           step
);
  always_comb begin
    case (pc)
      // serial-lane power-on
      6'd0:  step = wr(PART_ANA, 5'h00, 8'h80, 8'h00);
      6'd1:  step = wr(PART_ANA, 5'h00, 8'h03, 8'h01);
      6'd2:  step = wr(PART_LVDS, 5'h03, 8'h07, 8'h01);
      6'd3:  step = wr(PART_ANA, 5'h03, 8'h1F, {3'b000, prediv});
      6'd4:  step = wr(PART_ANA, 5'h03, 8'h20, {2'b00, fbdiv[8], 5'b00000});
      6'd5:  step = wr(PART_ANA, 5'h04, 8'hFF, fbdiv[7:0]);
      6'd6:  step = wr(PART_ANA, 5'h01, 8'h03, 8'h00);
      6'd7:  step = wr(PART_ANA, 5'h01, 8'h04, 8'h04);
      6'd8:  step = ctl(K_WAIT);
      6'd9:  step = wr(PART_ANA, 5'h01, 8'h04, 8'h00);
      6'd10: step = wr(PART_DIG, 5'h00, 8'h01, 8'h00);
      6'd11: step = ctl(K_WAIT);
      6'd12: step = wr(PART_DIG, 5'h00, 8'h01, 8'h01);
      6'd13: step = wr(PART_ANA, 5'h00, 8'h7C, 8'h7C);
      // LVDS power-on
      6'd16: step = wr(PART_ANA, 5'h00, 8'h80, 8'h00);
      6'd17: step = wr(PART_ANA, 5'h00, 8'h03, 8'h01);
      6'd18: step = wr(PART_ANA, 5'h08, 8'h30, 8'h10);
      6'd19: step = wr(PART_LVDS, 5'h03, 8'h07, 8'h02);
      6'd20: step = wr(PART_ANA, 5'h03, 8'h1F, 8'h02);
      6'd21: step = wr(PART_ANA, 5'h03, 8'h20, 8'h00);
      6'd22: step = wr(PART_ANA, 5'h04, 8'hFF, 8'h1C);
      6'd23: step = wr(PART_LVDS, 5'h08, 8'hFF, 8'hFC);
      6'd24: step = wr(PART_LVDS, 5'h0B, 8'h05, 8'h00);
      6'd25: step = ctl(K_POLL);
      6'd26: step = wr(PART_ANA, 5'h1E, 8'h60, 8'h00);
      6'd27: step = wr(PART_LVDS, 5'h00, 8'h04, 8'h00);
      6'd28: step = ctl(K_WAIT);
      6'd29: step = wr(PART_LVDS, 5'h00, 8'h04, 8'h04);
      6'd30: step = wr(PART_LVDS, 5'h01, 8'h80, 8'h80);
      6'd31: step = wr(PART_LVDS, 5'h0B, 8'hF8, 8'hF8);
      // TTL power-on
      6'd33: step = wr(PART_ANA, 5'h00, 8'h80, 8'h00);
      6'd34: step = wr(PART_ANA, 5'h00, 8'h03, 8'h01);
      6'd35: step = wr(PART_LVDS, 5'h03, 8'h07, 8'h04);
      6'd36: step = wr(PART_LVDS, 5'h00, 8'h04, 8'h00);
      6'd37: step = ctl(K_WAIT);
      6'd38: step = wr(PART_LVDS, 5'h00, 8'h04, 8'h04);
      6'd39: step = wr(PART_LVDS, 5'h01, 8'h80, 8'h80);
      6'd40: step = wr(PART_LVDS, 5'h0B, 8'hF8, 8'hF8);
      6'd41: step = ctl(K_HOST);
      // power-off
      6'd48: step = wr(PART_ANA, 5'h00, 8'h7C, 8'h00);
      6'd49: step = wr(PART_ANA, 5'h01, 8'h03, 8'h03);
      6'd50: step = wr(PART_ANA, 5'h00, 8'h03, 8'h02);
      6'd51: step = wr(PART_ANA, 5'h00, 8'h80, 8'h80);
      6'd52: step = wr(PART_LVDS, 5'h0B, 8'hF8, 8'h00);
      6'd53: step = wr(PART_LVDS, 5'h01, 8'h80, 8'h00);
      6'd54: step = wr(PART_LVDS, 5'h0B, 8'h05, 8'h05);
      default: step = ctl(K_END);
    endcase
  end
endmodule

// File: rtl/vphy_seq_ctrl.sv
module vphy_seq_ctrl
  import vphy_seq_pkg::*;
#(
  parameter int POLL_US         = 50,
  parameter int LOCK_TIMEOUT_US = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_on_req,
  input  logic            pwr_off_req,
  input  logic [1:0]      mode,
  input  logic [4:0]      prediv_in,
  input  logic [8:0]      fbdiv_in,
  input  logic            pll_lock,
  input  logic            bus_ready,
  input  kind_t           kind,
  input  logic            us_tick,
  output logic [PC_W-1:0] pc,
  output logic [4:0]      prediv_q,
  output logic [8:0]      fbdiv_q,
  output logic            timer_clear,
  output logic            bus_valid,
  output logic            host_clk_en,
  output logic            busy,
  output logic            done,
  output logic            lock_timeout
);
  localparam int TW = $clog2(LOCK_TIMEOUT_US + 1);
  localparam int GW = (POLL_US > 1) ? $clog2(POLL_US) : 1;
  localparam logic [TW-1:0] T_LIM    = TW'(LOCK_TIMEOUT_US);
  localparam logic [GW-1:0] GAP_LAST = GW'(POLL_US - 1);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_POLL} st_t;

  st_t           state;
  logic          chk;
  logic [GW-1:0] gap;
  logic [TW-1:0] total_us;

  assign busy        = (state != S_IDLE);
  assign bus_valid   = (state == S_EXEC) && (kind == K_WR);
  assign timer_clear = (state == S_EXEC) && (kind == K_WAIT || kind == K_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      pc           <= '0;
      prediv_q     <= '0;
      fbdiv_q      <= '0;
      host_clk_en  <= 1'b0;
      done         <= 1'b0;
      lock_timeout <= 1'b0;
      chk          <= 1'b0;
      gap          <= '0;
      total_us     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (pwr_off_req) begin
            pc           <= PC_OFF;
            state        <= S_EXEC;
            lock_timeout <= 1'b0;
          end else if (pwr_on_req) begin
            case (mode)
              2'b00:   pc <= PC_SER;
              2'b01:   pc <= PC_LVDS;
              default: pc <= PC_TTL;
            endcase
            prediv_q     <= prediv_in;
            fbdiv_q      <= fbdiv_in;
            state        <= S_EXEC;
            lock_timeout <= 1'b0;
          end
        end
        S_EXEC: begin
          case (kind)
            K_WR:   if (bus_ready) pc <= pc + PC_W'(1);
            K_WAIT: state <= S_WAIT;
            K_POLL: begin
              state    <= S_POLL;
              chk      <= 1'b1;
              gap      <= '0;
              total_us <= '0;
            end
            K_HOST: begin
              host_clk_en <= 1'b1;
              pc          <= pc + PC_W'(1);
            end
            default: begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
        S_WAIT: begin
          if (us_tick) begin
            state <= S_EXEC;
            pc    <= pc + PC_W'(1);
          end
        end
        default: begin
          if (chk) begin
            if (pll_lock) begin
              state <= S_EXEC;
              pc    <= pc + PC_W'(1);
            end else if (total_us >= T_LIM) begin
              lock_timeout <= 1'b1;
              state        <= S_EXEC;
              pc           <= pc + PC_W'(1);
            end else begin
              chk <= 1'b0;
            end
          end
          if (us_tick) begin
            if (total_us < T_LIM) total_us <= total_us + TW'(1);
            if (gap == GAP_LAST) begin
              gap <= '0;
              chk <= 1'b1;
            end else begin
              gap <= gap + GW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vphy_pwr_seq.sv
module vphy_pwr_seq
  import vphy_seq_pkg::*;
#(
  parameter int CYCLES_PER_US   = 100,
  parameter int POLL_US         = 50,
  parameter int LOCK_TIMEOUT_US = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic [1:0] mode,
  input  logic [4:0] prediv,
  input  logic [8:0] fbdiv,
  input  logic       pll_lock,
  output logic       bus_valid,
  input  logic       bus_ready,
  output logic [7:0] bus_addr,
  output logic [7:0] bus_mask,
  output logic [7:0] bus_data,
  output logic       host_clk_en,
  output logic       busy,
  output logic       done,
  output logic       lock_timeout
);
  logic [PC_W-1:0] pc;
  logic [4:0]      prediv_q;
  logic [8:0]      fbdiv_q;
  logic            timer_clear;
  logic            us_tick;
  step_t           step;

  vphy_us_timer #(.CYCLES_PER_US(CYCLES_PER_US)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .tick  (us_tick)
  );

  vphy_step_rom u_rom (
    .pc     (pc),
    .prediv (prediv_q),
    .fbdiv  (fbdiv_q),
    .step   (step)
  );

  vphy_seq_ctrl #(
    .POLL_US         (POLL_US),
    .LOCK_TIMEOUT_US (LOCK_TIMEOUT_US)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on_req   (pwr_on_req),
    .pwr_off_req  (pwr_off_req),
    .mode         (mode),
    .prediv_in    (prediv),
    .fbdiv_in     (fbdiv),
    .pll_lock     (pll_lock),
    .bus_ready    (bus_ready),
    .kind         (step.kind),
    .us_tick      (us_tick),
    .pc           (pc),
    .prediv_q     (prediv_q),
    .fbdiv_q      (fbdiv_q),
    .timer_clear  (timer_clear),
    .bus_valid    (bus_valid),
    .host_clk_en  (host_clk_en),
    .busy         (busy),
    .done         (done),
    .lock_timeout (lock_timeout)
  );

  assign bus_addr = bus_valid ? step.addr : 8'h00;
  assign bus_mask = bus_valid ? step.mask : 8'h00;
  assign bus_data = bus_valid ? step.data : 8'h00;
endmodule

// File: rtl/vphy_pwr_seq_chk.sv
module vphy_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on_req,
  input logic       pwr_off_req,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_mask,
  input logic [7:0] bus_data,
  input logic       host_clk_en,
  input logic       busy,
  input logic       done,
  input logic       lock_timeout
);
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_mask) && $stable(bus_data));

  a_r1_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy);

  a_r6_timeout_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_timeout) |-> busy);

  a_r7_host_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_clk_en) |-> 1'b0);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_on_req || pwr_off_req));
endmodule

bind vphy_pwr_seq vphy_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_on_req   (pwr_on_req),
  .pwr_off_req  (pwr_off_req),
  .bus_valid    (bus_valid),
  .bus_ready    (bus_ready),
  .bus_addr     (bus_addr),
  .bus_mask     (bus_mask),
  .bus_data     (bus_data),
  .host_clk_en  (host_clk_en),
  .busy         (busy),
  .done         (done),
  .lock_timeout (lock_timeout)
);

// File: tb/vphy_pwr_seq_bench.sv
module vphy_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_US     = 4;
  localparam int POLL       = 50;
  localparam int TOUT       = 10000;
  localparam int WD_LIMIT   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0;
  logic       pwr_off_req = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4:0] prediv = 5'd0;
  logic [8:0] fbdiv = 9'd0;
  logic       pll_lock = 1'b0;
  logic       bus_ready = 1'b0;
  logic       bus_valid;
  logic [7:0] bus_addr, bus_mask, bus_data;
  logic       host_clk_en, busy, done, lock_timeout;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_cnt = 0;
  int lock_at = -1;

  logic [23:0] exp_q [0:63];
  int          exp_n;
  logic [23:0] log_q [0:127];
  int          log_c [0:127];
  int          log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vphy_pwr_seq #(
    .CYCLES_PER_US(CYC_US), .POLL_US(POLL), .LOCK_TIMEOUT_US(TOUT)
  ) u_vphy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .mode(mode), .prediv(prediv), .fbdiv(fbdiv), .pll_lock(pll_lock),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_mask(bus_mask), .bus_data(bus_data), .host_clk_en(host_clk_en),
    .busy(busy), .done(done), .lock_timeout(lock_timeout)
  );

  // monitor: log accepted transactions
  always @(posedge clk) begin
    if (bus_valid && bus_ready && log_n < 128) begin
      log_q[log_n] = {bus_addr, bus_mask, bus_data};
      log_c[log_n] = cyc;
      log_n = log_n + 1;
    end
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // target stall pattern and PLL model
  always @(negedge clk) begin
    rdy_cnt = rdy_cnt + 1;
    bus_ready = (rdy_cnt % 3) != 2;
    if (lock_at >= 0 && cyc >= lock_at) pll_lock = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
    exp_q[exp_n] = {a, m, d};
    exp_n = exp_n + 1;
  endtask

  task automatic exp_prefix();
    push(8'h00, 8'h80, 8'h00);
    push(8'h00, 8'h03, 8'h01);
  endtask

  task automatic exp_tail();
    push(8'hE0, 8'h04, 8'h00);
    push(8'hE0, 8'h04, 8'h04);
    push(8'hE1, 8'h80, 8'h80);
    push(8'hEB, 8'hF8, 8'hF8);
  endtask

  task automatic exp_ser(input logic [4:0] p, input logic [8:0] f);
    exp_n = 0;
    exp_prefix();
    push(8'hE3, 8'h07, 8'h01);
    push(8'h03, 8'h1F, {3'b0, p});
    push(8'h03, 8'h20, {2'b0, f[8], 5'b0});
    push(8'h04, 8'hFF, f[7:0]);
    push(8'h01, 8'h03, 8'h00);
    push(8'h01, 8'h04, 8'h04);
    push(8'h01, 8'h04, 8'h00);
    push(8'h20, 8'h01, 8'h00);
    push(8'h20, 8'h01, 8'h01);
    push(8'h00, 8'h7C, 8'h7C);
  endtask

  task automatic exp_lvds();
    exp_n = 0;
    exp_prefix();
    push(8'h08, 8'h30, 8'h10);
    push(8'hE3, 8'h07, 8'h02);
    push(8'h03, 8'h1F, 8'h02);
    push(8'h03, 8'h20, 8'h00);
    push(8'h04, 8'hFF, 8'h1C);
    push(8'hE8, 8'hFF, 8'hFC);
    push(8'hEB, 8'h05, 8'h00);
    push(8'h1E, 8'h60, 8'h00);
    exp_tail();
  endtask

  task automatic exp_ttl();
    exp_n = 0;
    exp_prefix();
    push(8'hE3, 8'h07, 8'h04);
    exp_tail();
  endtask

  task automatic exp_off();
    exp_n = 0;
    push(8'h00, 8'h7C, 8'h00);
    push(8'h01, 8'h03, 8'h03);
    push(8'h00, 8'h03, 8'h02);
    push(8'h00, 8'h80, 8'h80);
    push(8'hEB, 8'hF8, 8'h00);
    push(8'hE1, 8'h80, 8'h00);
    push(8'hEB, 8'h05, 8'h05);
  endtask

  function automatic int find(input logic [23:0] v);
    for (int i = 0; i < log_n; i++) if (log_q[i] == v) return i;
    return -1;
  endfunction

  task automatic compare_log(input string req);
    check(log_n == exp_n, req, "transaction count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      check(log_q[i] == exp_q[i], req, $sformatf("transaction %0d", i),
            int'(log_q[i]), int'(exp_q[i]));
  endtask

  task automatic pulse_gap(input string req, input logic [23:0] a, input logic [23:0] b);
    int ia, ib;
    ia = find(a);
    ib = find(b);
    if (ia < 0 || ib < 0) check(1'b0, req, "reset pulse writes present", ia, ib);
    else check(log_c[ib] - log_c[ia] >= CYC_US, req, "reset pulse width cycles",
               log_c[ib] - log_c[ia], CYC_US);
  endtask

  // issue a request, check busy follows, wait for done
  task automatic run(input bit on, input bit off, input logic [1:0] m, input string req);
    log_n = 0;
    @(negedge clk);
    mode = m;
    pwr_on_req = on;
    pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 1'b0;
    pwr_off_req = 1'b0;
    check(busy == 1'b1, "R9", {req, " busy one cycle after request"}, busy, 1);
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R9", {req, " busy low with done"}, busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", {req, " done single cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check(!bus_valid && !busy && !done && !host_clk_en && !lock_timeout, "R10",
          "outputs after reset", {bus_valid, busy, done, host_clk_en, lock_timeout}, 0);
  endtask

  task automatic t_serial();
    prediv = 5'd3;
    fbdiv = 9'h15A;
    run(1'b1, 1'b0, 2'b00, "serial");
    exp_ser(5'd3, 9'h15A);
    compare_log("R3");
    check(log_q[0] == exp_q[0] && log_q[1] == exp_q[1], "R2", "power-on prefix",
          int'(log_q[0]), int'(exp_q[0]));
    pulse_gap("R4", {8'h01, 8'h04, 8'h04}, {8'h01, 8'h04, 8'h00});
    pulse_gap("R4", {8'h20, 8'h01, 8'h00}, {8'h20, 8'h01, 8'h01});
    check(host_clk_en == 1'b0, "R7", "host enable untouched by serial mode", host_clk_en, 0);
  endtask

  task automatic t_ignore_busy();
    prediv = 5'd9;
    fbdiv = 9'h0C0;
    log_n = 0;
    @(negedge clk);
    mode = 2'b00;
    pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0;
    repeat (3) @(negedge clk);
    mode = 2'b01;
    pwr_off_req = 1'b1;
    pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_off_req = 1'b0;
    pwr_on_req = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    exp_ser(5'd9, 9'h0C0);
    compare_log("R9");
    check(busy == 1'b0, "R9", "request during busy ignored", busy, 0);
  endtask

  task automatic t_off(input string tag);
    run(1'b0, 1'b1, 2'b00, tag);
    exp_off();
    compare_log("R8");
  endtask

  task automatic t_lvds_locked();
    pll_lock = 1'b1;
    run(1'b1, 1'b0, 2'b01, "lvds locked");
    exp_lvds();
    compare_log("R5");
    pulse_gap("R4", {8'hE0, 8'h04, 8'h00}, {8'hE0, 8'h04, 8'h04});
    check(lock_timeout == 1'b0, "R6", "no timeout when locked", lock_timeout, 0);
  endtask

  task automatic t_lvds_late();
    int i1e;
    pll_lock = 1'b0;
    lock_at = cyc + 100 * CYC_US;
    run(1'b1, 1'b0, 2'b01, "lvds late");
    exp_lvds();
    compare_log("R5");
    i1e = find({8'h1E, 8'h60, 8'h00});
    check(i1e >= 0 && log_c[i1e] >= lock_at, "R6", "continues only after lock",
          i1e >= 0 ? log_c[i1e] : -1, lock_at);
    check(i1e >= 0 && log_c[i1e] <= lock_at + POLL * CYC_US + 10, "R6",
          "lock seen within one poll interval", i1e >= 0 ? log_c[i1e] : -1,
          lock_at + POLL * CYC_US);
    check(lock_timeout == 1'b0, "R6", "no timeout on late lock", lock_timeout, 0);
    lock_at = -1;
  endtask

  task automatic t_lvds_timeout();
    int ieb, i1e;
    pll_lock = 1'b0;
    lock_at = -1;
    run(1'b1, 1'b0, 2'b01, "lvds timeout");
    exp_lvds();
    compare_log("R5");
    check(lock_timeout == 1'b1, "R6", "timeout flag set", lock_timeout, 1);
    ieb = find({8'hEB, 8'h05, 8'h00});
    i1e = find({8'h1E, 8'h60, 8'h00});
    check(ieb >= 0 && i1e >= 0 && log_c[i1e] - log_c[ieb] >= TOUT * CYC_US, "R6",
          "sequence held for the full timeout",
          (ieb >= 0 && i1e >= 0) ? log_c[i1e] - log_c[ieb] : -1, TOUT * CYC_US);
  endtask

  task automatic t_ttl();
    check(host_clk_en == 1'b0, "R7", "host enable low before TTL", host_clk_en, 0);
    run(1'b1, 1'b0, 2'b11, "ttl");
    exp_ttl();
    compare_log("R7");
    pulse_gap("R4", {8'hE0, 8'h04, 8'h00}, {8'hE0, 8'h04, 8'h04});
    check(host_clk_en == 1'b1, "R7", "host enable set by TTL", host_clk_en, 1);
  endtask

  task automatic t_both();
    run(1'b1, 1'b1, 2'b00, "both requests");
    exp_off();
    compare_log("R9");
    check(host_clk_en == 1'b1, "R7", "host enable kept through power-off", host_clk_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_serial();
    t_ignore_busy();
    t_off("off");
    t_lvds_locked();
    t_lvds_late();
    t_lvds_timeout();
    t_off("off after timeout");
    check(lock_timeout == 1'b0, "R6", "flag cleared by next request", lock_timeout, 0);
    t_ttl();
    t_both();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule